// File: doc/BRIEF.md
# Preamble Autocorrelation Frame Detector

This block watches a stream of signed complex baseband samples, one sample for each cycle in which `validIn` is high, and finds the start of a periodic preamble. Each accepted sample is multiplied, in conjugated form, by the sample accepted `LAG` strobes earlier. The products are summed over a sliding window of `WIN` products with no weighting and no division. The complex window sum is presented at full precision, so that a later angle unit can turn its phase into a carrier frequency offset. Its squared magnitude is formed in a short pipeline.

Detection keys on the rising edge of the correlation-power plateau, not on a normalised correlation level. The metric is the present squared magnitude minus the squared magnitude from `DIFF_LAG` accepted samples earlier. When this metric first exceeds `threshold`, a single-cycle pulse is raised. The detector then stays quiet until `rearm` is pulsed. `WIN` is meant to be a multiple of the shortest preamble period (16 samples), so that the power shows a flat plateau. One instance is placed for each lag that the receiver needs.

Top module: `preamble_corr_detect`

## Requirements
- R1: During and straight after reset, `corrValid`, `magValid` and `frameDetect` are low, `corrRe`, `corrIm` and `magSq` are zero, and the detector is armed. Samples from before reset count as zero.
- R2: On the clock edge that accepts sample n (`validIn` high), `corrRe`/`corrIm` take the value sum over j = n-WIN+1..n of conj(x[j])·x[j-LAG], with real part re·re'+im·im' and imaginary part re·im'-im·re' (unprimed: x[j], primed: x[j-LAG]). `corrValid` is high for exactly the cycle after that edge.
- R3: The correlation is carried in 2·SAMPLE_W+1+log2(WIN) bits. A run of full-scale samples (-2048, -2048) yields exactly 2^28 on the real part for the default parameters, with no wrap.
- R4: Cycles with `validIn` low change no state. The correlation and magnitude outputs hold their values, and idle gaps inside a stream do not alter any later result.
- R5: `magSq` equals corrRe² + corrIm² of the correlation of the same sample. It is updated two cycles after that correlation appears, with `magValid` high for that one cycle.
- R6: The metric is magSq(n) − magSq(n−DIFF_LAG), taken as a signed value. A detection needs the metric to be strictly greater than the unsigned `threshold`.
- R7: `frameDetect` is a one-cycle pulse in the cycle after `magValid` of the triggering sample, that is three cycles after its `corrValid`.
- R8: After a pulse, no further pulse occurs until `rearm` is high on a cycle that carries no pulse. On a cycle where a pulse fires, `rearm` is ignored.
- R9: No pulse is raised for the first LAG+WIN+DIFF_LAG−1 samples after reset, whatever the metric.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Sample strobe |
| sampleRe | input | SAMPLE_W (12) | In-phase sample, signed |
| sampleIm | input | SAMPLE_W (12) | Quadrature sample, signed |
| threshold | input | MAG_W (60) | Detection threshold for the metric, unsigned |
| rearm | input | 1 | Re-enables detection after a pulse |
| corrValid | output | 1 | Correlation updated |
| corrRe | output | ACC_W (30) | Window sum, real part, signed |
| corrIm | output | ACC_W (30) | Window sum, imaginary part, signed |
| magValid | output | 1 | Squared magnitude updated |
| magSq | output | MAG_W (60) | Squared magnitude of the correlation |
| frameDetect | output | 1 | Single-cycle detection pulse |

## Verification
The correlation of a sample is visible right after the edge that accepts it. Its squared magnitude follows two edges later, and any detection pulse for it one edge after that. The bench records which sample index, if any, was driven before each numbered edge. After every edge it samples on the falling clock and looks back zero, two and three edges in that record to know what `corrValid`, `magValid` and `frameDetect` must show. Between updates, the correlation and magnitude outputs are compared every cycle against the last value due, which also covers the idle gaps.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

  // Strobes issued by the control to move data through the datapath stages.
  typedef struct packed {
    logic stepIn;    // sample accepted: delay lines and window sum advance
    logic stepSq;    // squares of the new correlation are registered
    logic stepMag;   // squares are added into magSq
    logic stepDiff;  // metric is valid; magnitude history advances
  } pcdStrobe_t;

endpackage

// File: rtl/pcd_delay_line.sv
module pcd_delay_line #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             step,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut
);

  logic [WIDTH-1:0] stage [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
    end else if (step) begin
      stage[0] <= dataIn;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
    end
  end

  assign dataOut = stage[DEPTH-1];

  // R4: an idle strobe leaves the line untouched
  assert_line_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !step |=> $stable(dataOut));

endmodule

// File: rtl/pcd_datapath.sv
module pcd_datapath
  import pcd_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int LAG      = 16,
  parameter int WIN      = 32,
  parameter int DIFF_LAG = 16,
  localparam int PROD_W  = 2*SAMPLE_W + 1,
  localparam int ACC_W   = PROD_W + $clog2(WIN),
  localparam int MAG_W   = 2*ACC_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  pcdStrobe_t                 strobe,
  input  logic signed [SAMPLE_W-1:0] sampleRe,
  input  logic signed [SAMPLE_W-1:0] sampleIm,
  output logic signed [ACC_W-1:0]    corrRe,
  output logic signed [ACC_W-1:0]    corrIm,
  output logic        [MAG_W-1:0]    magSq,
  output logic signed [MAG_W:0]      metric
);

  localparam int MUL_W = 2*SAMPLE_W;
  localparam logic signed [ACC_W:0] ACC_BOUND = (ACC_W+1)'(WIN) << (MUL_W - 1);

  // ---------------- sample delay line (lag LAG) ----------------
  logic [2*SAMPLE_W-1:0] lagOut;
  logic signed [SAMPLE_W-1:0] lagRe, lagIm;

  pcd_delay_line #(.WIDTH(2*SAMPLE_W), .DEPTH(LAG)) i_sampleLine (
    .clk(clk), .rstN(rstN), .step(strobe.stepIn),
    .dataIn({sampleRe, sampleIm}), .dataOut(lagOut)
  );
  assign lagRe = lagOut[2*SAMPLE_W-1:SAMPLE_W];
  assign lagIm = lagOut[SAMPLE_W-1:0];

  // ---------------- conjugate product ----------------
  logic signed [MUL_W-1:0] mulRR, mulII, mulRI, mulIR;
  logic signed [PROD_W-1:0] prodRe, prodIm;

  always_comb begin
    mulRR  = sampleRe * lagRe;
    mulII  = sampleIm * lagIm;
    mulRI  = sampleRe * lagIm;
    mulIR  = sampleIm * lagRe;
    prodRe = {mulRR[MUL_W-1], mulRR} + {mulII[MUL_W-1], mulII};
    prodIm = {mulRI[MUL_W-1], mulRI} - {mulIR[MUL_W-1], mulIR};
  end

  // ---------------- window sum: add newest, drop oldest ----------------
  logic [2*PROD_W-1:0] leaveOut;
  logic signed [PROD_W-1:0] leaveRe, leaveIm;

  pcd_delay_line #(.WIDTH(2*PROD_W), .DEPTH(WIN)) i_prodLine (
    .clk(clk), .rstN(rstN), .step(strobe.stepIn),
    .dataIn({prodRe, prodIm}), .dataOut(leaveOut)
  );
  assign leaveRe = leaveOut[2*PROD_W-1:PROD_W];
  assign leaveIm = leaveOut[PROD_W-1:0];

  logic signed [ACC_W-1:0] nextRe, nextIm;
  always_comb begin
    nextRe = corrRe + {{(ACC_W-PROD_W){prodRe[PROD_W-1]}}, prodRe}
                    - {{(ACC_W-PROD_W){leaveRe[PROD_W-1]}}, leaveRe};
    nextIm = corrIm + {{(ACC_W-PROD_W){prodIm[PROD_W-1]}}, prodIm}
                    - {{(ACC_W-PROD_W){leaveIm[PROD_W-1]}}, leaveIm};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      corrRe <= '0;
      corrIm <= '0;
    end else if (strobe.stepIn) begin
      corrRe <= nextRe;
      corrIm <= nextIm;
    end
  end

  // ---------------- squared magnitude pipeline ----------------
  logic signed [MAG_W-1:0] sqReFull, sqImFull;
  logic [MAG_W-1:0] sqRe, sqIm;

  always_comb begin
    sqReFull = corrRe * corrRe;
    sqImFull = corrIm * corrIm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sqRe  <= '0;
      sqIm  <= '0;
      magSq <= '0;
    end else begin
      if (strobe.stepSq) begin
        sqRe <= unsigned'(sqReFull);
        sqIm <= unsigned'(sqImFull);
      end
      if (strobe.stepMag) magSq <= sqRe + sqIm;
    end
  end

  // ---------------- lagged difference of the power ----------------
  logic [MAG_W-1:0] oldMag;

  pcd_delay_line #(.WIDTH(MAG_W), .DEPTH(DIFF_LAG)) i_magLine (
    .clk(clk), .rstN(rstN), .step(strobe.stepDiff),
    .dataIn(magSq), .dataOut(oldMag)
  );

  assign metric = $signed({1'b0, magSq}) - $signed({1'b0, oldMag});

  // R4: no accepted sample, no change of the window sum
  assert_acc_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.stepIn |=> ($stable(corrRe) && $stable(corrIm)));

  // R5: the magnitude moves only on its own stage strobe
  assert_mag_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.stepMag |=> $stable(magSq));

  // R3: the window sum stays inside the range of WIN full-scale products
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($signed({corrRe[ACC_W-1], corrRe}) <= ACC_BOUND) &&
    ($signed({corrRe[ACC_W-1], corrRe}) >= -ACC_BOUND) &&
    ($signed({corrIm[ACC_W-1], corrIm}) <= ACC_BOUND) &&
    ($signed({corrIm[ACC_W-1], corrIm}) >= -ACC_BOUND));

endmodule

// File: rtl/pcd_control.sv
module pcd_control
  import pcd_pkg::*;
#(
  parameter int MAG_W      = 60,
  parameter int FILL_COUNT = 64,
  localparam int CNT_W     = $clog2(FILL_COUNT)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  validIn,
  input  logic                  rearm,
  input  logic [MAG_W-1:0]      threshold,
  input  logic signed [MAG_W:0] metric,
  output pcdStrobe_t            strobe,
  output logic                  corrValid,
  output logic                  magValid,
  output logic                  frameDetect
);

  logic vCorr, vSq, vMag;
  logic [CNT_W-1:0] fillCnt;
  logic armed;
  logic filled;
  logic fire;

  assign strobe.stepIn   = validIn;
  assign strobe.stepSq   = vCorr;
  assign strobe.stepMag  = vSq;
  assign strobe.stepDiff = vMag;

  assign corrValid = vCorr;
  assign magValid  = vMag;

  assign filled = (fillCnt == CNT_W'(FILL_COUNT - 1));
  assign fire   = vMag && filled && armed && (metric > $signed({1'b0, threshold}));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vCorr       <= 1'b0;
      vSq         <= 1'b0;
      vMag        <= 1'b0;
      fillCnt     <= '0;
      armed       <= 1'b1;
      frameDetect <= 1'b0;
    end else begin
      vCorr       <= validIn;
      vSq         <= vCorr;
      vMag        <= vSq;
      frameDetect <= fire;
      if (vMag && !filled) fillCnt <= fillCnt + 1'b1;
      if (fire)       armed <= 1'b0;
      else if (rearm) armed <= 1'b1;
    end
  end

  // R7: the pulse lasts one cycle
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameDetect |=> !frameDetect);

  // R8: a pulse leaves the detector disarmed
  assert_disarm_R8: assert property (@(posedge clk) disable iff (!rstN)
    frameDetect |-> !armed);

  // R9: no pulse before the history is full
  assert_fill_guard_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameDetect |-> filled);

  // R5: magnitude valid follows correlation valid through two stages
  assert_valid_chain_R5: assert property (@(posedge clk) disable iff (!rstN)
    corrValid |=> (vSq && ($past(vSq) == magValid)));

endmodule

// File: rtl/preamble_corr_detect.sv
module preamble_corr_detect
  import pcd_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int LAG      = 16,
  parameter int WIN      = 32,
  parameter int DIFF_LAG = 16,
  localparam int ACC_W   = 2*SAMPLE_W + 1 + $clog2(WIN),
  localparam int MAG_W   = 2*ACC_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       validIn,
  input  logic signed [SAMPLE_W-1:0] sampleRe,
  input  logic signed [SAMPLE_W-1:0] sampleIm,
  input  logic        [MAG_W-1:0]    threshold,
  input  logic                       rearm,
  output logic                       corrValid,
  output logic signed [ACC_W-1:0]    corrRe,
  output logic signed [ACC_W-1:0]    corrIm,
  output logic                       magValid,
  output logic        [MAG_W-1:0]    magSq,
  output logic                       frameDetect
);

  localparam int FILL_COUNT = LAG + WIN + DIFF_LAG;

  pcdStrobe_t strobe;
  logic signed [MAG_W:0] metric;

  pcd_control #(.MAG_W(MAG_W), .FILL_COUNT(FILL_COUNT)) i_control (
    .clk(clk), .rstN(rstN), .validIn(validIn), .rearm(rearm),
    .threshold(threshold), .metric(metric), .strobe(strobe),
    .corrValid(corrValid), .magValid(magValid), .frameDetect(frameDetect)
  );

  pcd_datapath #(.SAMPLE_W(SAMPLE_W), .LAG(LAG), .WIN(WIN), .DIFF_LAG(DIFF_LAG)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .sampleRe(sampleRe), .sampleIm(sampleIm),
    .corrRe(corrRe), .corrIm(corrIm), .magSq(magSq), .metric(metric)
  );

endmodule

// File: tb/test_preamble_corr_detect.sv
`timescale 1ns/1ps
module test_preamble_corr_detect;

  localparam int SAMPLE_W = 12;
  localparam int LAG      = 16;
  localparam int WIN      = 32;
  localparam int DIFF_LAG = 16;
  localparam int ACC_W    = 2*SAMPLE_W + 1 + $clog2(WIN);
  localparam int MAG_W    = 2*ACC_W;
  localparam int FILL     = LAG + WIN + DIFF_LAG;
  localparam int MAXS     = 1024;
  localparam int MAXC     = 2048;
  localparam longint THR  = 64'd1000000000000;

  // kind: 0 noise, 1 period-16 preamble, 2 full scale, 3 zeros
  typedef struct packed {
    int len; int kind; int gap; int rearmFirst; int expDet;
  } row_t;
  localparam int NROWS = 8;
  localparam row_t ROWS [NROWS] = '{
    '{40,  1, 0, 0, 0},   // fill phase: metric high but suppressed (R9)
    '{100, 0, 0, 0, 0},   // noise, power falls
    '{120, 1, 3, 0, 1},   // preamble with idle gaps: one pulse
    '{60,  0, 0, 0, 0},
    '{80,  1, 0, 0, 0},   // disarmed: no pulse (R8)
    '{60,  0, 0, 1, 0},   // rearm before this row
    '{80,  2, 0, 0, 1},   // full-scale run: one pulse
    '{40,  3, 0, 0, 0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic validIn = 1'b0;
  logic signed [SAMPLE_W-1:0] sampleRe = '0, sampleIm = '0;
  logic [MAG_W-1:0] threshold;
  logic rearm = 1'b0;
  logic corrValid, magValid, frameDetect;
  logic signed [ACC_W-1:0] corrRe, corrIm;
  logic [MAG_W-1:0] magSq;

  always #4 clk = ~clk;   // 125 MHz
  assign threshold = MAG_W'(THR);

  preamble_corr_detect #(.SAMPLE_W(SAMPLE_W), .LAG(LAG), .WIN(WIN), .DIFF_LAG(DIFF_LAG))
  i_preamble_corr_detect (
    .clk(clk), .rstN(rstN), .validIn(validIn), .sampleRe(sampleRe), .sampleIm(sampleIm),
    .threshold(threshold), .rearm(rearm), .corrValid(corrValid), .corrRe(corrRe),
    .corrIm(corrIm), .magValid(magValid), .magSq(magSq), .frameDetect(frameDetect)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // model state, indexed by sample number (1-based, 0 = nothing yet)
  longint xRe [MAXS], xIm [MAXS], pRe [MAXS], pIm [MAXS];
  longint cRe [MAXS], cIm [MAXS], mag [MAXS];
  bit     expDet [MAXS];
  int     rowOf [MAXS];
  int     drv [MAXC];
  int     seen [NROWS];
  int     nSamp = 0, cyc = 0, curC = 0, curM = 0;
  bit     modelArmed = 1'b1;
  int     lcg = 32'h1234_5678;
  int     lastFullScale = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic checkCycle(input int c);
    int n0, n2, n3;
    bit e;
    n0 = drv[c];
    n2 = (c >= 2) ? drv[c-2] : 0;
    n3 = (c >= 3) ? drv[c-3] : 0;
    if (n0 != 0) curC = n0;
    if (n2 != 0) curM = n2;
    chk(corrValid == (n0 != 0), "R2", "corrValid", longint'(corrValid), longint'(n0 != 0));
    chk(longint'(corrRe) == cRe[curC], (n0 != 0) ? "R2" : "R4", "corrRe",
        longint'(corrRe), cRe[curC]);
    chk(longint'(corrIm) == cIm[curC], (n0 != 0) ? "R2" : "R4", "corrIm",
        longint'(corrIm), cIm[curC]);
    chk(magValid == (n2 != 0), "R5", "magValid", longint'(magValid), longint'(n2 != 0));
    chk(longint'(magSq) == mag[curM], "R5", "magSq", longint'(magSq), mag[curM]);
    e = (n3 != 0) && expDet[n3];
    chk(frameDetect == e, "R7", "frameDetect", longint'(frameDetect), longint'(e));
    if (frameDetect && n3 != 0) seen[rowOf[n3]]++;
  endtask

  // one clock: drive at the falling edge, check at the next falling edge
  task automatic step(input bit v, input int re, input int im, input bit rq);
    validIn  = v;
    sampleRe = SAMPLE_W'(re);
    sampleIm = SAMPLE_W'(im);
    rearm    = rq;
    drv[cyc+1] = v ? nSamp : 0;
    @(posedge clk);
    cyc++;
    @(negedge clk);
    validIn = 1'b0;
    rearm   = 1'b0;
    checkCycle(cyc);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(1'b0, 0, 0, 1'b0);
  endtask

  task automatic doRearm();
    modelArmed = 1'b1;
    step(1'b0, 0, 0, 1'b1);
  endtask

  task automatic gen(input int kind, input int k, output int re, output int im);
    case (kind)
      0: begin
        lcg = lcg * 1103515245 + 12345;
        re  = ((lcg >>> 16) & 127) - 64;
        lcg = lcg * 1103515245 + 12345;
        im  = ((lcg >>> 16) & 127) - 64;
      end
      1: begin
        re = (((k % 16) * 137) % 31 - 15) * 60;
        im = (((k % 16) * 53) % 29 - 14) * 60;
      end
      2: begin re = -2048; im = -2048; end
      default: begin re = 0; im = 0; end
    endcase
  endtask

  // golden model from R2, R5, R6, R8, R9
  task automatic accept(input int re, input int im, input int r);
    longint dRe, dIm, oRe, oIm, met;
    nSamp++;
    xRe[nSamp] = re; xIm[nSamp] = im; rowOf[nSamp] = r;
    dRe = (nSamp > LAG) ? xRe[nSamp-LAG] : 0;
    dIm = (nSamp > LAG) ? xIm[nSamp-LAG] : 0;
    pRe[nSamp] = xRe[nSamp]*dRe + xIm[nSamp]*dIm;
    pIm[nSamp] = xRe[nSamp]*dIm - xIm[nSamp]*dRe;
    oRe = (nSamp > WIN) ? pRe[nSamp-WIN] : 0;
    oIm = (nSamp > WIN) ? pIm[nSamp-WIN] : 0;
    cRe[nSamp] = cRe[nSamp-1] + pRe[nSamp] - oRe;
    cIm[nSamp] = cIm[nSamp-1] + pIm[nSamp] - oIm;
    mag[nSamp] = cRe[nSamp]*cRe[nSamp] + cIm[nSamp]*cIm[nSamp];
    met = mag[nSamp] - ((nSamp > DIFF_LAG) ? mag[nSamp-DIFF_LAG] : 0);
    expDet[nSamp] = (nSamp >= FILL) && modelArmed && (met > THR);
    if (expDet[nSamp]) modelArmed = 1'b0;
    step(1'b1, re, im, 1'b0);
  endtask

  initial begin
    int re, im;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(corrValid == 1'b0, "R1", "corrValid in reset", longint'(corrValid), 0);
    chk(magValid == 1'b0, "R1", "magValid in reset", longint'(magValid), 0);
    chk(frameDetect == 1'b0, "R1", "frameDetect in reset", longint'(frameDetect), 0);
    chk(corrRe == '0, "R1", "corrRe in reset", longint'(corrRe), 0);
    chk(magSq == '0, "R1", "magSq in reset", longint'(magSq), 0);
    rstN = 1'b1;
    idle(2);

    // table walk
    for (int r = 0; r < NROWS; r++) begin
      if (ROWS[r].rearmFirst != 0) begin
        idle(4);
        doRearm();
      end
      for (int k = 0; k < ROWS[r].len; k++) begin
        if (ROWS[r].gap != 0 && (k % ROWS[r].gap) == ROWS[r].gap - 1) idle(1);
        gen(ROWS[r].kind, k, re, im);
        accept(re, im, r);
      end
      if (ROWS[r].kind == 2) lastFullScale = nSamp;
    end
    idle(6);

    // directed outcomes per row
    for (int r = 0; r < NROWS; r++) begin
      if (r == 0)
        chk(seen[r] == ROWS[r].expDet, "R9", "pulses during fill", seen[r], ROWS[r].expDet);
      else if (r == 4)
        chk(seen[r] == ROWS[r].expDet, "R8", "pulses while disarmed", seen[r], ROWS[r].expDet);
      else
        chk(seen[r] == ROWS[r].expDet, "R6", "pulses in row", seen[r], ROWS[r].expDet);
    end
    // R3: full-scale window sum equals WIN * 2 * 2048^2
    chk(cRe[lastFullScale] == 64'd268435456, "R3", "model full-scale sum",
        cRe[lastFullScale], 64'd268435456);
    chk(longint'(corrRe) == cRe[nSamp], "R3", "held correlation after run",
        longint'(corrRe), cRe[nSamp]);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule